// File: doc/BRIEF.md
# M-ary FSK Frequency Modulator Core

This block turns a stream of bytes into a phase-continuous frequency-shift-keyed baseband signal expressed as a running 32-bit phase word. Each byte is split into bits, most significant bit first. The bits are gathered into symbols of one, two or three bits, as the modulation code selects. Each symbol is mapped to an odd-integer frequency level, and that level is scaled by a fixed-point modulation index. The result is added to a signed centre-frequency word to form the per-sample phase increment, and a 32-bit accumulator integrates the increment on every clock.

Symbols are paced by a divider, so each symbol lasts 2^n processing clocks. When the internal bit store holds too few bits at a symbol boundary, the block sends the bare centre frequency for that symbol and raises an underflow flag. The Gaussian code values are accepted and modulate exactly like their plain counterparts: no pulse shaping is applied.

Top module: `fsk_mod_core`

## Requirements
- R1: A symbol boundary occurs once every 2^n clocks, where n is `cfg_rate_exp` (0 to 15). `sym_strobe` is high for exactly the one clock after each boundary edge. `freq_out` and `underflow` change only on those edges.
- R2: The number of bits per symbol follows `cfg_mod_type`: codes 0 and 1 take one bit, codes 2 and 3 take two bits, codes 4 and 5 take three bits. The unused codes 6 and 7 take one bit.
- R3: Bytes are serialized MSB first. Within a symbol the first bit taken is the most significant bit of the symbol value k. A symbol may take bits from two consecutive bytes.
- R4: A symbol value k out of M = 2^bits levels maps to the signed level 2k − (M − 1).
- R5: After a boundary that has enough bits, `freq_out` = (`cfg_center` + level · h · 2^(23−n)) mod 2^32. Here h is `cfg_index`, read as unsigned with 3 integer and 8 fractional bits.
- R6: On every clock outside reset, `phase_out` advances by the `freq_out` value of the previous clock, modulo 2^32. The accumulator is cleared only by reset.
- R7: If fewer bits than one symbol needs are stored at a boundary, no bits are consumed. `freq_out` becomes `cfg_center` and `underflow` is high until the next boundary.
- R8: `in_ready` is high while 8 or fewer bits are stored. A byte moves when `in_valid` and `in_ready` are both high at a clock edge. A byte taken on a boundary edge is not used by the symbol formed on that edge.
- R9: While reset is held, `phase_out`, `freq_out`, `sym_strobe` and `underflow` are zero and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing (sample) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rate_exp | input | 4 | Symbol length exponent n: 2^n clocks per symbol |
| cfg_mod_type | input | 3 | Modulation code (selects 1, 2 or 3 bits per symbol) |
| cfg_index | input | 11 | Modulation index h, unsigned, 8 fractional bits |
| cfg_center | input | 32 | Centre-frequency word, two's complement |
| in_byte | input | 8 | Data byte |
| in_valid | input | 1 | Data byte present |
| in_ready | output | 1 | Bit store can take a byte |
| phase_out | output | 32 | Accumulated phase word |
| freq_out | output | 32 | Current per-sample phase increment |
| sym_strobe | output | 1 | One-clock pulse after each symbol boundary |
| underflow | output | 1 | Current symbol was sent without data |

## Verification
Byte acceptance and symbol consumption can land on the same clock edge. The bench provokes this by streaming bytes continuously at n = 0, where every edge is a boundary, and at small n with three-bit symbols whose bits span byte edges. It also runs sparse feeding that forces repeated underflow next to late arrivals. The bench keeps its own queue of sent bits. At every boundary it predicts underflow from the queue occupancy, then pops the symbol before it appends a byte taken on that same edge. Any mix-up in the order of consume and append then appears as a wrong increment or a wrong underflow flag.

// File: rtl/fsk_mod_pkg.sv
package fsk_mod_pkg;

    localparam int PHASE_W  = 32;
    localparam int INDEX_W  = 11;
    localparam int RATE_W   = 4;
    localparam int BYTE_W   = 8;
    localparam int SYM_W    = 3;
    localparam int STORE_W  = 2 * BYTE_W;
    localparam int FILL_W   = $clog2(STORE_W + 1);
    localparam int FRAC_SHIFT = 23;

    typedef struct packed {
        logic [STORE_W-1:0] bits;
        logic [FILL_W-1:0]  fill;
    } store_state_t;

    typedef struct packed {
        logic [PHASE_W-1:0] inc;
        logic               strobe;
        logic               underflow;
    } core_state_t;

    function automatic logic [1:0] bits_per_symbol(input logic [2:0] code);
        case (code)
            3'd2, 3'd3: return 2'd2;
            3'd4, 3'd5: return 2'd3;
            default:    return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/fsk_symbol_timer.sv
module fsk_symbol_timer #(
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_exp,
    output logic              tick
);
    localparam int CNT_W = 2 ** RATE_W;

    logic [CNT_W-1:0] cnt_d, cnt_q, last;

    always_comb begin
        last  = CNT_W'((64'd1 << rate_exp) - 64'd1);
        tick  = (cnt_q >= last);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1: a boundary with n > 0 cannot be followed by another one clock later
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rate_exp != '0) |=> (!tick || rate_exp == '0))
        else $error("symbol boundaries too close");

endmodule

// File: rtl/fsk_bit_store.sv
module fsk_bit_store
    import fsk_mod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        sym_bits,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              have_sym,
    output logic [SYM_W-1:0]  sym_value
);
    store_state_t st_d, st_q;
    logic         take, accept;
    logic [STORE_W-1:0] after_bits;
    logic [FILL_W-1:0]  after_fill;
    logic [STORE_W-1:0] incoming;

    always_comb begin
        in_ready = (st_q.fill <= FILL_W'(BYTE_W));
        have_sym = (st_q.fill >= FILL_W'(sym_bits));
        accept   = in_valid && in_ready;
        take     = tick && have_sym;

        case (sym_bits)
            2'd2:    sym_value = {1'b0, st_q.bits[STORE_W-1 -: 2]};
            2'd3:    sym_value = st_q.bits[STORE_W-1 -: 3];
            default: sym_value = {2'b00, st_q.bits[STORE_W-1]};
        endcase

        after_bits = st_q.bits;
        after_fill = st_q.fill;
        if (take) begin
            after_bits = st_q.bits << sym_bits;
            after_fill = st_q.fill - FILL_W'(sym_bits);
        end

        incoming = {in_byte, {(STORE_W-BYTE_W){1'b0}}} >> after_fill;
        st_d = st_q;
        st_d.bits = after_bits;
        st_d.fill = after_fill;
        if (accept) begin
            st_d.bits = after_bits | incoming;
            st_d.fill = after_fill + FILL_W'(BYTE_W);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: a starved boundary with no arriving byte leaves the store untouched
    p_starve_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !have_sym && !accept) |=> (st_q.fill == $past(st_q.fill)))
        else $error("bits consumed on underflow");

    // R8: fill never exceeds the store capacity
    p_fill_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fill <= FILL_W'(STORE_W))
        else $error("bit store overfilled");

    // R8: an accepted byte with no consumption adds exactly one byte of bits
    p_accept_grow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !take) |=> (st_q.fill == $past(st_q.fill) + FILL_W'(BYTE_W)))
        else $error("byte accept miscounted");

endmodule

// File: rtl/fsk_level_scaler.sv
module fsk_level_scaler
    import fsk_mod_pkg::*;
(
    input  logic [SYM_W-1:0]   sym_value,
    input  logic [1:0]         sym_bits,
    input  logic [INDEX_W-1:0] index_h,
    input  logic [RATE_W-1:0]  rate_exp,
    input  logic [PHASE_W-1:0] center,
    output logic [PHASE_W-1:0] inc_data
);
    localparam int PROD_W = INDEX_W + SYM_W + 3;

    logic [4:0]                span;
    logic signed [PROD_W-1:0]  level;
    logic signed [PROD_W-1:0]  h_ext;
    logic signed [PROD_W-1:0]  prod;
    logic signed [PHASE_W-1:0] prod_ext;
    logic [4:0]                shamt;
    logic [PHASE_W-1:0]        dev;

    always_comb begin
        span     = (5'd1 << sym_bits) - 5'd1;
        level    = $signed(PROD_W'({sym_value, 1'b0})) - $signed(PROD_W'(span));
        h_ext    = $signed(PROD_W'(index_h));
        prod     = level * h_ext;
        prod_ext = PHASE_W'(prod);
        shamt    = 5'(FRAC_SHIFT) - {1'b0, rate_exp};
        dev      = PHASE_W'(prod_ext <<< shamt);
        inc_data = center + dev;
    end

endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc
    import fsk_mod_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] inc,
    output logic [PHASE_W-1:0] phase
);
    logic [PHASE_W-1:0] phase_d, phase_q;

    always_comb phase_d = phase_q + inc;

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    assign phase = phase_q;

    // R6: phase moves by the increment that was applied one clock earlier
    p_phase_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (phase_q == $past(phase_q) + $past(inc)))
        else $error("phase discontinuity");

endmodule

// File: rtl/fsk_mod_core.sv
module fsk_mod_core
    import fsk_mod_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          cfg_rate_exp,
    input  logic [2:0]          cfg_mod_type,
    input  logic [10:0]         cfg_index,
    input  logic [31:0]         cfg_center,
    input  logic [7:0]          in_byte,
    input  logic                in_valid,
    output logic                in_ready,
    output logic [31:0]         phase_out,
    output logic [31:0]         freq_out,
    output logic                sym_strobe,
    output logic                underflow
);
    logic               tick;
    logic [1:0]         sym_bits;
    logic               have_sym;
    logic [SYM_W-1:0]   sym_value;
    logic [PHASE_W-1:0] inc_data;
    core_state_t        cs_d, cs_q;

    always_comb sym_bits = bits_per_symbol(cfg_mod_type);

    fsk_symbol_timer #(.RATE_W(RATE_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_exp (cfg_rate_exp),
        .tick     (tick)
    );

    fsk_bit_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .sym_bits  (sym_bits),
        .in_byte   (in_byte),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .have_sym  (have_sym),
        .sym_value (sym_value)
    );

    fsk_level_scaler u_scaler (
        .sym_value (sym_value),
        .sym_bits  (sym_bits),
        .index_h   (cfg_index),
        .rate_exp  (cfg_rate_exp),
        .center    (cfg_center),
        .inc_data  (inc_data)
    );

    always_comb begin
        cs_d = cs_q;
        cs_d.strobe = 1'b0;
        if (tick) begin
            cs_d.strobe    = 1'b1;
            cs_d.underflow = !have_sym;
            cs_d.inc       = have_sym ? inc_data : cfg_center;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    fsk_phase_acc u_nco (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cs_q.inc),
        .phase (phase_out)
    );

    assign freq_out   = cs_q.inc;
    assign sym_strobe = cs_q.strobe;
    assign underflow  = cs_q.underflow;

    // R1: increment and flag hold steady between boundaries
    p_hold_between_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_q.strobe && $past(rst_n)) |-> ($stable(cs_q.inc) && $stable(cs_q.underflow)))
        else $error("increment changed off boundary");

    // R7: a starved symbol carries the bare centre frequency
    p_idle_center_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q.strobe && cs_q.underflow && $past(rst_n)) |-> (cs_q.inc == $past(cfg_center)))
        else $error("underflow symbol not at centre");

endmodule

// File: tb/tb_fsk_mod_core.sv
module tb_fsk_mod_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_rate_exp = '0;
    logic [2:0]  cfg_mod_type = '0;
    logic [10:0] cfg_index = '0;
    logic [31:0] cfg_center = '0;
    logic [7:0]  in_byte = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] phase_out, freq_out;
    logic        sym_strobe, underflow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fsk_mod_core dut (
        .clk(clk), .rst_n(rst_n), .cfg_rate_exp(cfg_rate_exp),
        .cfg_mod_type(cfg_mod_type), .cfg_index(cfg_index),
        .cfg_center(cfg_center), .in_byte(in_byte), .in_valid(in_valid),
        .in_ready(in_ready), .phase_out(phase_out), .freq_out(freq_out),
        .sym_strobe(sym_strobe), .underflow(underflow)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int bps_of(input int code);
        if (code == 2 || code == 3) return 2;
        if (code == 4 || code == 5) return 3;
        return 1;
    endfunction

    function automatic logic [31:0] expect_inc(input int k, input int bps, input int h,
                                               input int n, input logic [31:0] c);
        longint lvl, d;
        lvl = 2 * k - ((1 << bps) - 1);
        d   = lvl * h * (longint'(1) << (23 - n));
        return c + d[31:0];
    endfunction

    task automatic run_config(input int idx, input int mtype, input int n,
                              input int h, input logic [31:0] c, input bit sparse);
        bit q[$];
        int bps, sent, last_strobe, cyc, run_len, k;
        bit pend, have_prev, seen_strobe;
        logic [7:0] pend_byte;
        logic [31:0] prev_phase, prev_freq;
        bps = bps_of(mtype);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        cfg_mod_type = 3'(mtype); cfg_rate_exp = 4'(n);
        cfg_index = 11'(h); cfg_center = c;
        repeat (2) @(negedge clk);
        // R9: reset state
        check(phase_out == 0 && freq_out == 0, "R9 phase/freq reset", longint'(freq_out), 0);
        check(!sym_strobe && !underflow && in_ready, "R9 flags reset",
              longint'({sym_strobe, underflow, in_ready}), 1);
        rst_n = 1'b1;
        sent = 0; pend = 0; have_prev = 0; seen_strobe = 0; last_strobe = 0;
        prev_phase = '0; prev_freq = '0;
        run_len = 100 + (6 * 8 + 8) * (1 << n);
        for (cyc = 0; cyc < run_len; cyc++) begin
            @(negedge clk);
            if (have_prev)   // R6
                check(phase_out == prev_phase + prev_freq, "R6 phase step",
                      longint'(phase_out), longint'(32'(prev_phase + prev_freq)));
            if (sym_strobe) begin
                if (seen_strobe)   // R1
                    check(cyc - last_strobe == (1 << n), "R1 symbol period",
                          cyc - last_strobe, 1 << n);
                seen_strobe = 1; last_strobe = cyc;
                if (q.size() < bps) begin   // R7
                    check(underflow == 1'b1, "R7 underflow flag", underflow, 1);
                    check(freq_out == c, "R7 centre on underflow", longint'(freq_out), longint'(c));
                end else begin   // R2 R3 R4 R5
                    k = 0;
                    for (int b = 0; b < bps; b++) k = (k << 1) | int'(q.pop_front());
                    check(underflow == 1'b0, "R2 symbol present", underflow, 0);
                    check(freq_out == expect_inc(k, bps, h, n, c), "R5 increment R4 level R3 order",
                          longint'(freq_out), longint'(expect_inc(k, bps, h, n, c)));
                end
            end else if (have_prev) begin
                check(freq_out == prev_freq, "R1 hold between boundaries",
                      longint'(freq_out), longint'(prev_freq));
            end
            // R8: byte taken at the last edge is appended after that edge's symbol
            if (pend)
                for (int b = 7; b >= 0; b--) q.push_back(pend_byte[b]);
            pend = 0;
            prev_phase = phase_out; prev_freq = freq_out; have_prev = 1;
            if (sent < 6 && (!sparse || (cyc % 29) < 3)) begin
                in_valid = 1'b1;
                in_byte  = 8'((idx * 29 + sent * 71 + 5) ^ (sent << 3));
            end else begin
                in_valid = 1'b0;
            end
            if (in_valid && in_ready) begin
                pend = 1; pend_byte = in_byte; sent++;
            end
        end
        in_valid = 1'b0;
        check(sent == 6, "R8 all bytes accepted", sent, 6);
    endtask

    initial begin
        int idx;
        int nlist[3];
        int hlist[3];
        nlist = '{0, 2, 5};
        hlist = '{128, 43, 2047};
        idx = 0;
        for (int m = 0; m < 8; m++)
            for (int ni = 0; ni < 3; ni++)
                for (int hi = 0; hi < 3; hi++) begin
                    run_config(idx, m, nlist[ni], hlist[hi],
                               (idx % 2 == 0) ? 32'h0123_4567 * 32'(idx + 1) : 32'hF000_0000 - 32'(idx * 977),
                               (idx % 3) == 1);
                    idx++;
                end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule